// File: doc/BRIEF.md
# Single-Precision Floating-Point Subtractor

This block computes x minus y for two 32-bit IEEE 754 single-precision operands and returns a correctly rounded 32-bit difference. A 2-bit input selects the rounding direction. A one-bit flag reports an invalid operation. The block registers its result, so the difference for the operands presented before a rising clock edge appears on the outputs after that edge.

Each operand is first sorted into one of six classes: zero, subnormal, normal, infinity, quiet NaN or signalling NaN. Pairs involving NaNs, infinities or zeros are settled by a fixed priority order. Every other pair goes through the arithmetic path. On that path y's sign is flipped and the two values are added. The significands first get three extra low bits. The one with the smaller exponent is then shifted right, and every bit shifted out is folded into the sticky bit. The magnitudes are added or subtracted, the result is normalised and then rounded. A parameter can make subnormal inputs act as signed zeros. By default it is off.

Top module: `fp_sub_sp`

## Requirements
- R1: A signalling NaN (exponent all ones, nonzero fraction, fraction bit 22 clear) in x gives x with bit 22 set and raises the invalid flag, whatever y is. Otherwise, a signalling NaN in y gives y with bit 22 set and raises the invalid flag.
- R2: If neither operand is a signalling NaN, a quiet NaN in x is returned unchanged. Otherwise, a quiet NaN in y is returned unchanged.
- R3: Infinity minus infinity with opposite signs returns x. With equal signs it returns 0x7FC00000 and raises the invalid flag.
- R4: A finite x minus an infinite y gives an infinity with the sign opposite to y's sign. An infinite x minus a finite y returns x.
- R5: Zero minus zero with opposite signs returns x. With equal signs it returns a zero whose sign is set only under round toward minus infinity.
- R6: A nonzero finite x minus a zero returns x. A zero minus a nonzero finite y returns y with bit 31 inverted.
- R7: For finite nonzero operands the result is x minus y, rounded to nearest with ties to even when the mode is 00.
- R8: An exact cancellation of finite operands gives +0, except in mode 11, where it gives -0.
- R9: Mode 01 rounds toward zero, mode 10 toward plus infinity and mode 11 toward minus infinity. Guard, round and sticky information decides the rounding.
- R10: A rounded magnitude beyond the largest finite value gives infinity in modes 00, 10 when positive and 11 when negative. In the other cases it gives the largest finite value of that sign (exponent 0xFE, fraction all ones).
- R11: Subnormal operands take part with full precision. Results below the normal range are denormalised before rounding. Bits lost in any alignment shift still count toward rounding.
- R12: The outputs are registered with one cycle of latency, and an asynchronous active-low reset clears both to zero.
- R13: The invalid flag is raised only for the signalling-NaN cases of R1 and the equal-sign infinity case of R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_x | input | 32 | Minuend, single precision |
| op_y | input | 32 | Subtrahend, single precision |
| rnd_mode | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| diff_q | output | 32 | Registered difference |
| invalid_q | output | 1 | Registered invalid-operation flag |

## Verification
The hardest case to reach from the ports is one where rounding depends on bits that the alignment shift has pushed far below the significand. This happens when a one-ulp subnormal is subtracted from 1.0 with an exponent gap of well over a hundred. The only evidence that the bits existed is the sticky bit, which turns a tie into a round-up or keeps a truncation one ulp lower. Directed vectors build these cases explicitly: an exact half-ulp tie below 1.0, a quarter-ulp excess above it, and the far-gap sticky case. Each is run under the rounding modes that separate the outcomes. Random normal operands, some drawn close together to force deep cancellation, are checked against a double-precision reference that the bench rounds back to single precision by itself.

// File: rtl/fp_sub_sp.sv
module fp_sub_sp #(
  parameter bit FLUSH_SUBNORM = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] op_x,
  input  logic [31:0] op_y,
  input  logic [1:0]  rnd_mode,
  output logic [31:0] diff_q,
  output logic        invalid_q
);

  localparam logic [1:0]  RM_NE = 2'd0;
  localparam logic [1:0]  RM_TZ = 2'd1;
  localparam logic [1:0]  RM_UP = 2'd2;
  localparam logic [1:0]  RM_DN = 2'd3;
  localparam logic [31:0] QNAN_DFLT = 32'h7FC0_0000;
  localparam logic [31:0] QUIET_BIT = 32'h0040_0000;

  function automatic logic [4:0] lzc27(input logic [26:0] v);
    logic [4:0] n;
    n = 5'd27;
    for (int i = 0; i < 27; i++)
      if (v[i]) n = 5'(26 - i);
    return n;
  endfunction

  function automatic logic [26:0] shr_st(input logic [26:0] v, input logic [10:0] s);
    logic [26:0] mask;
    if (s >= 11'd27) return {26'd0, |v};
    mask = (27'd1 << s) - 27'd1;
    return (v >> s) | {26'd0, |(v & mask)};
  endfunction

  function automatic logic [34:0] unpack(input logic [7:0] e, input logic [22:0] f);
    logic [4:0] n;
    if (e != 8'd0) return {3'b000, e, 1'b1, f};
    n = lzc27({1'b0, f, 3'b000});
    return {11'(11'd1 - {6'd0, n}), 24'({1'b0, f} << n)};
  endfunction

  function automatic logic [31:0] pack(input logic s, input logic signed [10:0] e_in,
                                       input logic [26:0] m_in, input logic [1:0] rm);
    logic signed [10:0] e;
    logic [26:0] m;
    logic        den, g, st, inc, to_inf;
    logic [24:0] k;
    logic [22:0] frac;
    e = e_in;
    m = m_in;
    den = 1'b0;
    if (e < 11'sd1) begin
      m = shr_st(m, 11'(11'sd1 - e));
      den = 1'b1;
      e = 11'sd0;
    end
    g  = m[2];
    st = |m[1:0];
    case (rm)
      RM_NE:   inc = g & (st | m[3]);
      RM_TZ:   inc = 1'b0;
      RM_UP:   inc = ~s & (g | st);
      default: inc = s & (g | st);
    endcase
    k = {1'b0, m[26:3]} + {24'd0, inc};
    if (den) return {s, 7'd0, k[23], k[22:0]};
    if (k[24]) begin
      e = e + 11'sd1;
      frac = k[23:1];
    end else begin
      frac = k[22:0];
    end
    if (e >= 11'sd255) begin
      to_inf = (rm == RM_NE) || (rm == RM_UP && !s) || (rm == RM_DN && s);
      return to_inf ? {s, 8'hFF, 23'd0} : {s, 8'hFE, {23{1'b1}}};
    end
    return {s, e[7:0], frac};
  endfunction

  wire xs = op_x[31];
  wire ys = op_y[31];
  wire x_emax = &op_x[30:23];
  wire y_emax = &op_y[30:23];
  wire x_ezero = op_x[30:23] == 8'd0;
  wire y_ezero = op_y[30:23] == 8'd0;
  wire x_fnz = |op_x[22:0];
  wire y_fnz = |op_y[22:0];

  wire x_nan  = x_emax & x_fnz;
  wire y_nan  = y_emax & y_fnz;
  wire x_snan = x_nan & ~op_x[22];
  wire y_snan = y_nan & ~op_y[22];
  wire x_qnan = x_nan & op_x[22];
  wire y_qnan = y_nan & op_y[22];
  wire x_inf  = x_emax & ~x_fnz;
  wire y_inf  = y_emax & ~y_fnz;
  wire x_zero = x_ezero & (~x_fnz | FLUSH_SUBNORM);
  wire y_zero = y_ezero & (~y_fnz | FLUSH_SUBNORM);
  wire [31:0] x_val = x_zero ? {xs, 31'd0} : op_x;

  logic [34:0]        ux, uy;
  logic signed [10:0] ex, ey, eg;
  logic [26:0]        mx, my, ma, mb, mg, dif;
  logic [27:0]        sum;
  logic [4:0]         nsh;
  logic               sb, sg;
  logic [31:0]        gen, res;
  logic               inv;

  always_comb begin
    ux  = unpack(op_x[30:23], op_x[22:0]);
    uy  = unpack(op_y[30:23], op_y[22:0]);
    ex  = $signed(ux[34:24]);
    ey  = $signed(uy[34:24]);
    mx  = {ux[23:0], 3'b000};
    my  = {uy[23:0], 3'b000};
    sb  = ~ys;
    sum = 28'd0;
    dif = 27'd0;
    nsh = 5'd0;
    mg  = 27'd0;
    sg  = xs;
    gen = 32'd0;
    if (ex >= ey) begin
      ma = mx;
      mb = shr_st(my, 11'(ex - ey));
      eg = ex;
    end else begin
      ma = shr_st(mx, 11'(ey - ex));
      mb = my;
      eg = ey;
    end
    if (xs == sb) begin
      sum = {1'b0, ma} + {1'b0, mb};
      if (sum[27]) begin
        mg = {sum[27:2], |sum[1:0]};
        eg = eg + 11'sd1;
      end else begin
        mg = sum[26:0];
      end
      gen = pack(sg, eg, mg, rnd_mode);
    end else begin
      if (ma >= mb) begin
        dif = ma - mb;
        sg  = xs;
      end else begin
        dif = mb - ma;
        sg  = sb;
      end
      if (dif == 27'd0) begin
        gen = {rnd_mode == RM_DN, 31'd0};
      end else begin
        nsh = lzc27(dif);
        mg  = dif << nsh;
        eg  = eg - $signed({6'd0, nsh});
        gen = pack(sg, eg, mg, rnd_mode);
      end
    end
  end

  always_comb begin
    inv = 1'b0;
    res = gen;
    if (x_snan) begin
      res = op_x | QUIET_BIT;
      inv = 1'b1;
    end else if (y_snan) begin
      res = op_y | QUIET_BIT;
      inv = 1'b1;
    end else if (x_qnan) begin
      res = op_x;
    end else if (y_qnan) begin
      res = op_y;
    end else if (x_inf && y_inf) begin
      if (xs != ys) res = op_x;
      else begin
        res = QNAN_DFLT;
        inv = 1'b1;
      end
    end else if (y_inf) begin
      res = {~ys, 8'hFF, 23'd0};
    end else if (x_inf) begin
      res = op_x;
    end else if (x_zero && y_zero) begin
      res = (xs != ys) ? x_val : {rnd_mode == RM_DN, 31'd0};
    end else if (y_zero) begin
      res = x_val;
    end else if (x_zero) begin
      res = {~ys, op_y[30:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      diff_q    <= 32'd0;
      invalid_q <= 1'b0;
    end else begin
      diff_q    <= res;
      invalid_q <= inv;
    end
  end

  // R1
  invalid_gives_quiet_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_q |-> (diff_q[30:23] == 8'hFF) && diff_q[22]);

  // R13
  no_spurious_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!x_nan && !y_nan && !(x_inf && y_inf)) |=> !invalid_q);

  // R2
  quiet_x_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (x_qnan && !y_snan) |=> diff_q == $past(op_x));

  // R4
  finite_minus_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (y_inf && !x_emax) |=> diff_q == {~$past(op_y[31]), 8'hFF, 23'd0});

  // R8
  self_cancel_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_x == op_y && !x_emax) |=> diff_q == {$past(rnd_mode) == RM_DN, 31'd0});

endmodule

// File: tb/fp_sub_sp_tb.sv
module fp_sub_sp_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 41;
  localparam int NRAND = 400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_x = 32'd0, op_y = 32'd0;
  logic [1:0]  rnd_mode = 2'd0;
  logic [31:0] diff_q;
  logic        invalid_q;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  fp_sub_sp u_dut (.clk(clk), .rst_n(rst_n), .op_x(op_x), .op_y(op_y),
                   .rnd_mode(rnd_mode), .diff_q(diff_q), .invalid_q(invalid_q));

  always #(CLK_PERIOD/2) clk = ~clk;

  // {x, y, mode, expected, invalid}
  localparam logic [98:0] VEC [NV] = '{
    {32'h3F800000, 32'h3F800000, 2'd0, 32'h00000000, 1'b0},
    {32'h3F800000, 32'h3F800000, 2'd3, 32'h80000000, 1'b0},
    {32'h40000000, 32'h3F800000, 2'd0, 32'h3F800000, 1'b0},
    {32'h3F800000, 32'h40000000, 2'd0, 32'hBF800000, 1'b0},
    {32'h3F800000, 32'hBF800000, 2'd0, 32'h40000000, 1'b0},
    {32'h3FC00000, 32'hBFC00000, 2'd0, 32'h40400000, 1'b0},
    {32'h3F800000, 32'h7F800001, 2'd0, 32'h7FC00001, 1'b1},
    {32'hFF800005, 32'h7F800001, 2'd0, 32'hFFC00005, 1'b1},
    {32'h7F800002, 32'h7FC00000, 2'd0, 32'h7FC00002, 1'b1},
    {32'h00000000, 32'hFFC00123, 2'd0, 32'hFFC00123, 1'b0},
    {32'h7FC00456, 32'h7F800000, 2'd0, 32'h7FC00456, 1'b0},
    {32'h7F800000, 32'h7F800000, 2'd0, 32'h7FC00000, 1'b1},
    {32'h7F800000, 32'hFF800000, 2'd0, 32'h7F800000, 1'b0},
    {32'h3F800000, 32'h7F800000, 2'd0, 32'hFF800000, 1'b0},
    {32'h00000000, 32'hFF800000, 2'd0, 32'h7F800000, 1'b0},
    {32'hFF800000, 32'h3F800000, 2'd0, 32'hFF800000, 1'b0},
    {32'h00000000, 32'h80000000, 2'd0, 32'h00000000, 1'b0},
    {32'h80000000, 32'h00000000, 2'd3, 32'h80000000, 1'b0},
    {32'h80000000, 32'h80000000, 2'd3, 32'h80000000, 1'b0},
    {32'h80000000, 32'h80000000, 2'd0, 32'h00000000, 1'b0},
    {32'h00000000, 32'h00000000, 2'd2, 32'h00000000, 1'b0},
    {32'h3F800000, 32'h00000000, 2'd0, 32'h3F800000, 1'b0},
    {32'h00000000, 32'h3F800000, 2'd0, 32'hBF800000, 1'b0},
    {32'h00000000, 32'h00000001, 2'd0, 32'h80000001, 1'b0},
    {32'h3F800000, 32'h33000000, 2'd0, 32'h3F800000, 1'b0},
    {32'h3F800000, 32'h33000000, 2'd1, 32'h3F7FFFFF, 1'b0},
    {32'h3F800000, 32'h33000000, 2'd2, 32'h3F800000, 1'b0},
    {32'h3F800000, 32'h33000000, 2'd3, 32'h3F7FFFFF, 1'b0},
    {32'h3F800000, 32'hB3000000, 2'd2, 32'h3F800001, 1'b0},
    {32'hBF800000, 32'h33000000, 2'd3, 32'hBF800001, 1'b0},
    {32'hBF800000, 32'h33000000, 2'd2, 32'hBF800000, 1'b0},
    {32'h7F7FFFFF, 32'hFF7FFFFF, 2'd0, 32'h7F800000, 1'b0},
    {32'h7F7FFFFF, 32'hFF7FFFFF, 2'd1, 32'h7F7FFFFF, 1'b0},
    {32'h7F7FFFFF, 32'hFF7FFFFF, 2'd3, 32'h7F7FFFFF, 1'b0},
    {32'hFF7FFFFF, 32'h7F7FFFFF, 2'd2, 32'hFF7FFFFF, 1'b0},
    {32'hFF7FFFFF, 32'h7F7FFFFF, 2'd3, 32'hFF800000, 1'b0},
    {32'h00000003, 32'h00000001, 2'd0, 32'h00000002, 1'b0},
    {32'h00800000, 32'h00000001, 2'd0, 32'h007FFFFF, 1'b0},
    {32'h3F800000, 32'h00000001, 2'd1, 32'h3F7FFFFF, 1'b0},
    {32'h3F800000, 32'h00000001, 2'd0, 32'h3F800000, 1'b0},
    {32'h7F7FFFFF, 32'h3F800000, 2'd0, 32'h7F7FFFFF, 1'b0}
  };

  function automatic string vec_tag(input int i);
    if (i < 2)  return "R8";
    if (i < 6)  return "R7";
    if (i < 9)  return "R1";
    if (i < 11) return "R2";
    if (i < 13) return "R3";
    if (i < 16) return "R4";
    if (i < 21) return "R5";
    if (i < 24) return "R6";
    if (i < 31) return "R9";
    if (i < 36) return "R10";
    if (i < 40) return "R11";
    return "R7";
  endfunction

  function automatic real s2r(input logic [31:0] b);
    return $bitstoreal({b[31], {3'b000, b[30:23]} + 11'd896, b[22:0], 29'd0});
  endfunction

  function automatic logic [31:0] r2s(input real r);
    logic [63:0] d;
    logic [52:0] m;
    logic [24:0] k;
    logic [10:0] e;
    logic        inc;
    d = $realtobits(r);
    if (d[62:0] == 63'd0) return {d[63], 31'd0};
    m = {1'b1, d[51:0]};
    inc = m[28] & ((|m[27:0]) | m[29]);
    k = {1'b0, m[52:29]} + {24'd0, inc};
    e = d[62:52] - 11'd896;
    if (k[24]) return {d[63], e[7:0] + 8'd1, 23'd0};
    return {d[63], e[7:0], k[22:0]};
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] x, input logic [31:0] y, input logic [1:0] rm);
    @(negedge clk);
    op_x = x;
    op_y = y;
    rnd_mode = rm;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rx, ry, rexp;
    op_x = 32'h3F800000;
    op_y = 32'hBF800000;
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12", "reset diff", diff_q, 32'd0);
    check("R12", "reset invalid", {31'd0, invalid_q}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][98:67], VEC[i][66:35], VEC[i][34:33]);
      check(vec_tag(i), $sformatf("vec %0d result", i), diff_q, VEC[i][32:1]);
      check(VEC[i][0] ? vec_tag(i) : "R13", $sformatf("vec %0d invalid", i),
            {31'd0, invalid_q}, {31'd0, VEC[i][0]});
    end

    // R12: one-cycle latency, output holds until the next edge
    apply(32'h40000000, 32'h3F800000, 2'd0);
    op_x = 32'h3F800000;
    op_y = 32'h7F800001;
    #1;
    check("R12", "hold before edge", diff_q, 32'h3F800000);
    @(negedge clk);
    check("R12", "update after edge", diff_q, 32'h7FC00001);

    // R12: asynchronous reset mid-run
    #2;
    rst_n = 1'b0;
    #1;
    check("R12", "async reset diff", diff_q, 32'd0);
    check("R12", "async reset invalid", {31'd0, invalid_q}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R7, R13: random normal operands in nearest-even mode
    for (int i = 0; i < NRAND; i++) begin
      rx = {1'($urandom), 8'(100 + $urandom % 55), 23'($urandom)};
      if (i % 4 == 0)
        ry = {rx[31:8] ^ {23'd0, 1'($urandom)}, 8'($urandom)};
      else
        ry = {1'($urandom), 8'(100 + $urandom % 55), 23'($urandom)};
      rexp = r2s(s2r(rx) - s2r(ry));
      apply(rx, ry, 2'd0);
      check("R7", $sformatf("random %08h - %08h", rx, ry), diff_q, rexp);
      check("R13", "random invalid", {31'd0, invalid_q}, 32'd0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule